// File: doc/BRIEF.md
# Card Bus Access Cycle Timer

This block sequences a single access on the card bus. Each access runs through three phases in a fixed order. First an address setup phase, then a command phase in which the memory or I/O command strobe is active, then a recovery phase. The length of each phase is a clock-cycle count held in a timing set. The block keeps two independent timing sets, and the window that hits an access chooses one of them with its set-select bit. The block does not decode windows itself, so the caller presents the select bit together with the start request.

A card can stretch the command phase by raising its wait input. At the end of recovery the block emits a one-cycle completion pulse. A simple write port programs the six counts. A rising edge on the power-good input restores both sets to their defaults: a zero-wait profile in set 0 and a one-wait-state profile in set 1. The values in flight are captured when an access starts, so reprogramming never disturbs a running access.

Top module: `card_cycle_timer`

## Requirements
- R1: While reset is asserted, and directly after it, `mem_cmd`, `io_cmd` and `done` are low, and both timing sets hold their default counts.
- R2: After a start is accepted, no strobe is active for exactly as many cycles as the setup count of the chosen set.
- R3: The command strobe then stays active for exactly as many cycles as the command count, and recovery lasts the recovery count.
- R4: `done` is high for exactly one cycle, in the cycle after recovery ends, and no strobe is active while it is high.
- R5: A count of 0 gives a phase of one cycle.
- R6: `win_sel` = 0 times the access from set 0 and `win_sel` = 1 times it from set 1.
- R7: Defaults are: set 0 setup 1, command 2, recovery 1; set 1 setup 1, command 3, recovery 1. A rising edge of `pwr_good` reloads them and overwrites any programmed value.
- R8: Each cycle in which `card_wait` is high at a clock edge during the command phase keeps the strobe active and adds one cycle to that phase.
- R9: A start request made while an access is in progress, before its `done` cycle, is ignored.
- R10: A write to a timing set during an access leaves that access unchanged and applies from the next access.
- R11: `is_io` = 1 drives `io_cmd`, `is_io` = 0 drives `mem_cmd`, and the two strobes are never active together.
- R12: A write with `cfg_wr` high stores `cfg_data` in set `cfg_set`, field `cfg_field` (0 setup, 1 command, 2 recovery). Field code 3 changes nothing, and the other set is not touched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good level; rising edge reloads default timing |
| cfg_wr | input | 1 | Timing write strobe |
| cfg_set | input | 1 | Timing set addressed by the write |
| cfg_field | input | 2 | Field addressed: 0 setup, 1 command, 2 recovery |
| cfg_data | input | CNT_W | Count written |
| start | input | 1 | Start request for one access |
| win_sel | input | 1 | Timing set chosen by the hit window |
| is_io | input | 1 | Access type: 1 I/O, 0 memory |
| card_wait | input | 1 | Card wait request, stretches the command phase |
| mem_cmd | output | 1 | Memory command strobe, active high |
| io_cmd | output | 1 | I/O command strobe, active high |
| done | output | 1 | One-cycle pulse when the access completes |

## Verification
The bench uses the default parameters: 8-bit counts with the zero-wait and one-wait default profiles. Because the counter width is 8, the bench can program the largest count of 255 and run it in full, along with the zero count that is raised to one cycle. The bench also drives the default command counts, which differ between the two sets, so a swapped set selection or a skipped power-good reload changes the measured strobe length.

// File: rtl/ccyc_pkg.sv
package ccyc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_CMD   = 2'd2,
    PH_REC   = 2'd3
  } ccyc_phase_e;

  localparam int unsigned N_SETS   = 2;
  localparam int unsigned N_FIELDS = 3;

  localparam logic [1:0] FLD_SETUP = 2'd0;
  localparam logic [1:0] FLD_CMD   = 2'd1;
  localparam logic [1:0] FLD_REC   = 2'd2;
endpackage

// File: rtl/ccyc_regs.sv
module ccyc_regs
  import ccyc_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned DEF0_SETUP = 1,
  parameter int unsigned DEF0_CMD   = 2,
  parameter int unsigned DEF0_REC   = 1,
  parameter int unsigned DEF1_SETUP = 1,
  parameter int unsigned DEF1_CMD   = 3,
  parameter int unsigned DEF1_REC   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good,
  input  logic             wr_en,
  input  logic             wr_set,
  input  logic [1:0]       wr_field,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_set,
  output logic [CNT_W-1:0] rd_setup,
  output logic [CNT_W-1:0] rd_cmd,
  output logic [CNT_W-1:0] rd_rec
);

  logic [CNT_W-1:0] tim_q [N_SETS][N_FIELDS];
  logic [CNT_W-1:0] tim_d [N_SETS][N_FIELDS];
  logic             tim_en [N_SETS][N_FIELDS];
  logic             pg_q;
  logic             pg_rise;

  function automatic logic [CNT_W-1:0] def_val(input int s, input int f);
    int unsigned v;
    if (s == 0) v = (f == 0) ? DEF0_SETUP : (f == 1) ? DEF0_CMD : DEF0_REC;
    else        v = (f == 0) ? DEF1_SETUP : (f == 1) ? DEF1_CMD : DEF1_REC;
    return CNT_W'(v);
  endfunction

  assign pg_rise = pwr_good & ~pg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg_q <= 1'b0;
    else        pg_q <= pwr_good;
  end

  // next-state: power-good reload wins over a software write
  always_comb begin
    for (int s = 0; s < N_SETS; s++) begin
      for (int f = 0; f < N_FIELDS; f++) begin
        tim_en[s][f] = 1'b0;
        tim_d[s][f]  = tim_q[s][f];
        if (pg_rise) begin
          tim_en[s][f] = 1'b1;
          tim_d[s][f]  = def_val(s, f);
        end else if (wr_en && wr_set == 1'(s) && wr_field == 2'(f)) begin
          tim_en[s][f] = 1'b1;
          tim_d[s][f]  = wr_data;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N_SETS; s++)
        for (int f = 0; f < N_FIELDS; f++)
          tim_q[s][f] <= def_val(s, f);
    end else begin
      for (int s = 0; s < N_SETS; s++)
        for (int f = 0; f < N_FIELDS; f++)
          if (tim_en[s][f]) tim_q[s][f] <= tim_d[s][f];
    end
  end

  assign rd_setup = tim_q[rd_set][FLD_SETUP];
  assign rd_cmd   = tim_q[rd_set][FLD_CMD];
  assign rd_rec   = tim_q[rd_set][FLD_REC];

endmodule

// File: rtl/ccyc_seq.sv
module ccyc_seq
  import ccyc_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             io_req,
  input  logic             card_wait,
  input  logic [CNT_W-1:0] len_setup,
  input  logic [CNT_W-1:0] len_cmd,
  input  logic [CNT_W-1:0] len_rec,
  output logic             mem_cmd,
  output logic             io_cmd,
  output logic             done
);

  ccyc_phase_e      phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cmd_ld_q, cmd_ld_d;
  logic [CNT_W-1:0] rec_ld_q, rec_ld_d;
  logic             io_q, io_d;
  logic             done_q, done_d;
  logic             cnt_zero;

  // counter preload: a phase of N cycles starts at N-1, zero behaves as one
  function automatic logic [CNT_W-1:0] preload(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - CNT_W'(1);
  endfunction

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    cmd_ld_d = cmd_ld_q;
    rec_ld_d = rec_ld_q;
    io_d     = io_q;
    done_d   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d  = PH_SETUP;
          cnt_d    = preload(len_setup);
          cmd_ld_d = preload(len_cmd);
          rec_ld_d = preload(len_rec);
          io_d     = io_req;
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          phase_d = PH_CMD;
          cnt_d   = cmd_ld_q;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_CMD: begin
        if (!card_wait) begin
          if (cnt_zero) begin
            phase_d = PH_REC;
            cnt_d   = rec_ld_q;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
      PH_REC: begin
        if (cnt_zero) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      cmd_ld_q <= '0;
      rec_ld_q <= '0;
      io_q     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      cmd_ld_q <= cmd_ld_d;
      rec_ld_q <= rec_ld_d;
      io_q     <= io_d;
      done_q   <= done_d;
    end
  end

  assign mem_cmd = (phase_q == PH_CMD) && !io_q;
  assign io_cmd  = (phase_q == PH_CMD) &&  io_q;
  assign done    = done_q;

endmodule

// File: rtl/card_cycle_timer.sv
module card_cycle_timer
  import ccyc_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned DEF0_SETUP = 1,
  parameter int unsigned DEF0_CMD   = 2,
  parameter int unsigned DEF0_REC   = 1,
  parameter int unsigned DEF1_SETUP = 1,
  parameter int unsigned DEF1_CMD   = 3,
  parameter int unsigned DEF1_REC   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good,
  input  logic             cfg_wr,
  input  logic             cfg_set,
  input  logic [1:0]       cfg_field,
  input  logic [CNT_W-1:0] cfg_data,
  input  logic             start,
  input  logic             win_sel,
  input  logic             is_io,
  input  logic             card_wait,
  output logic             mem_cmd,
  output logic             io_cmd,
  output logic             done
);

  logic [CNT_W-1:0] sel_setup, sel_cmd, sel_rec;

  ccyc_regs #(
    .CNT_W(CNT_W),
    .DEF0_SETUP(DEF0_SETUP), .DEF0_CMD(DEF0_CMD), .DEF0_REC(DEF0_REC),
    .DEF1_SETUP(DEF1_SETUP), .DEF1_CMD(DEF1_CMD), .DEF1_REC(DEF1_REC)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .wr_en    (cfg_wr),
    .wr_set   (cfg_set),
    .wr_field (cfg_field),
    .wr_data  (cfg_data),
    .rd_set   (win_sel),
    .rd_setup (sel_setup),
    .rd_cmd   (sel_cmd),
    .rd_rec   (sel_rec)
  );

  ccyc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .io_req    (is_io),
    .card_wait (card_wait),
    .len_setup (sel_setup),
    .len_cmd   (sel_cmd),
    .len_rec   (sel_rec),
    .mem_cmd   (mem_cmd),
    .io_cmd    (io_cmd),
    .done      (done)
  );

endmodule

// File: rtl/card_cycle_timer_chk.sv
module card_cycle_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic card_wait,
  input logic mem_cmd,
  input logic io_cmd,
  input logic done
);

  logic chk_busy;
  logic strobe;

  assign strobe = mem_cmd | io_cmd;

  // tracks an access from the port side: accepted start until done
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chk_busy <= 1'b0;
    else if (!chk_busy) chk_busy <= start;
    else if (done)      chk_busy <= start;
  end

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_cmd && io_cmd)); // R11

  AST_TYPE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd |=> !io_cmd); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !strobe); // R4

  AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (!chk_busy || done)) |=> !strobe); // R2

  AST_STROBE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> chk_busy); // R9

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && card_wait) |=> strobe); // R8

endmodule

bind card_cycle_timer card_cycle_timer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .card_wait (card_wait),
  .mem_cmd   (mem_cmd),
  .io_cmd    (io_cmd),
  .done      (done)
);

// File: tb/tb_card_cycle_timer.sv
module tb_card_cycle_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n, pwr_good, cfg_wr, cfg_set, start, win_sel, is_io, card_wait;
  logic [1:0] cfg_field;
  logic [CNT_W-1:0] cfg_data;
  logic mem_cmd, io_cmd, done;

  card_cycle_timer #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .cfg_wr(cfg_wr), .cfg_set(cfg_set), .cfg_field(cfg_field), .cfg_data(cfg_data),
    .start(start), .win_sel(win_sel), .is_io(is_io), .card_wait(card_wait),
    .mem_cmd(mem_cmd), .io_cmd(io_cmd), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    s;
    int    c;
    int    r;
    bit    io;
    string req;
  } item_t;

  item_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int model [2][3];
  bit finished = 0;

  function automatic int plen(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic load_defaults();
    model[0][0] = 1; model[0][1] = 2; model[0][2] = 1;
    model[1][0] = 1; model[1][1] = 3; model[1][2] = 1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic cfg_write(input bit set, input logic [1:0] fld, input int val);
    cfg_wr = 1; cfg_set = set; cfg_field = fld; cfg_data = CNT_W'(val);
    if (fld != 2'd3) model[set][fld] = val;
    step();
    cfg_wr = 0;
    step();
  endtask

  // driver: one access, expected item pushed into the scoreboard
  task automatic run(input bit sel, input bit io, input int w, input bit extra_start,
                     input bit mw, input logic [1:0] mw_fld, input int mw_val,
                     input string req);
    item_t it;
    int n;
    it.s = plen(model[sel][0]);
    it.c = plen(model[sel][1]) + w;
    it.r = plen(model[sel][2]);
    it.io = io;
    it.req = req;
    exp_q.push_back(it);
    win_sel = sel; is_io = io; start = 1; card_wait = (w > 0);
    step(); n = 1;
    start = 0;
    if (extra_start || mw) begin
      step(); n = 2;
      start = extra_start;
      if (mw) begin
        cfg_wr = 1; cfg_set = sel; cfg_field = mw_fld; cfg_data = CNT_W'(mw_val);
        model[sel][mw_fld] = mw_val;
      end
      step(); n = 3;
      start = 0; cfg_wr = 0;
    end
    if (w > 0) begin
      while (n < it.s + w + 1) begin step(); n++; end
      card_wait = 0;
    end
    forever begin
      @(negedge clk);
      if (done) break;
    end
    step();
  endtask

  // monitor: measures each access at the ports and compares
  bit mbusy = 0;
  int ms, mc, mr;
  bit mio, mmem;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (mbusy) begin
        if (mem_cmd || io_cmd) begin
          mc++;
          if (io_cmd) mio = 1;
          if (mem_cmd) mmem = 1;
        end else if (done) begin
          mbusy = 0;
          if (exp_q.size() == 0) begin
            check(0, "R9", "unexpected access", 1, 0);
          end else begin
            item_t e;
            bit ok;
            e = exp_q.pop_front();
            ok = (ms == e.s) && (mc == e.c) && (mr == e.r) &&
                 (mio == e.io) && (mmem == !e.io);
            n_cmp++;
            if (!ok) begin
              n_bad++;
              $display("FAIL %s access: actual s=%0d c=%0d r=%0d io=%0d mem=%0d expected s=%0d c=%0d r=%0d io=%0d",
                       e.req, ms, mc, mr, mio, mmem, e.s, e.c, e.r, e.io);
            end
          end
        end else if (mc == 0) ms++;
        else mr++;
      end else if (start) begin
        mbusy = 1; ms = 0; mc = 0; mr = 0; mio = 0; mmem = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R4 watchdog: done count actual 0 expected 1");
    finished = 1;
    summary();
  end

  initial begin
    rst_n = 0; pwr_good = 0; cfg_wr = 0; cfg_set = 0; cfg_field = 0; cfg_data = 0;
    start = 0; win_sel = 0; is_io = 0; card_wait = 0;
    load_defaults();
    repeat (3) @(negedge clk);
    check(!mem_cmd && !io_cmd && !done, "R1", "outputs in reset", {mem_cmd, io_cmd, done}, 0);
    step(); rst_n = 1;
    @(negedge clk);
    check(!mem_cmd && !io_cmd && !done, "R1", "outputs after reset", {mem_cmd, io_cmd, done}, 0);
    step();
    run(0, 0, 0, 0, 0, 2'd0, 0, "R1");   // reset-time defaults, set 0
    pwr_good = 1; step(); step();
    run(0, 0, 0, 0, 0, 2'd0, 0, "R6");   // set 0 mem
    run(1, 1, 0, 0, 0, 2'd0, 0, "R11");  // set 1 io
    cfg_write(0, 2'd0, 3);
    cfg_write(0, 2'd1, 4);
    cfg_write(0, 2'd2, 2);
    cfg_write(0, 2'd3, 99);              // R12 unused field code
    run(0, 0, 0, 0, 0, 2'd0, 0, "R3");
    run(1, 0, 0, 0, 0, 2'd0, 0, "R12");  // other set untouched
    cfg_write(1, 2'd0, 0);
    cfg_write(1, 2'd1, 0);
    cfg_write(1, 2'd2, 0);
    run(1, 1, 0, 0, 0, 2'd0, 0, "R5");
    run(0, 1, 3, 0, 0, 2'd0, 0, "R8");
    run(0, 0, 0, 1, 1, 2'd1, 6, "R9");   // extra start + mid write (R10)
    run(0, 0, 0, 0, 0, 2'd0, 0, "R10");  // new command count applies now
    cfg_write(1, 2'd0, 255);
    run(1, 0, 0, 0, 0, 2'd0, 0, "R2");
    pwr_good = 0; step(); step();
    pwr_good = 1; load_defaults(); step(); step();
    run(0, 0, 0, 0, 0, 2'd0, 0, "R7");
    run(1, 1, 0, 0, 0, 2'd0, 0, "R7");
    repeat (4) step();
    @(negedge clk);
    check(!done && !mem_cmd && !io_cmd, "R4", "idle after last access", {mem_cmd, io_cmd, done}, 0);
    check(exp_q.size() == 0, "R4", "accesses left unmatched", exp_q.size(), 0);
    finished = 1;
    summary();
  end

endmodule